// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

This block joins two eight-input priority interrupt cores into a single sixteen-line controller. Lines 0 to 7 belong to the primary core and lines 8 to 15 to the secondary core. Whenever the secondary core has a request ready to be served, it sets a pulse request on line 2 of the primary. The primary's single request then drives one registered interrupt output towards the CPU.

Software reaches both cores, and their per-core trigger-mode registers, through a byte-wide I/O space. An address decoder routes each access, and any access that is not one byte wide is discarded. When the CPU acknowledges, the block runs a two-level handshake and returns one 8-bit vector. If the primary's winner is the cascade line, the acknowledge falls through to the secondary. Each level has its own spurious vector for the case where no request is left to serve.

Top module: `cascade_pic`

## Requirements
- R1: Byte accesses decode as follows: 0x020 is the primary command port, 0x021 the primary data port, 0x0A0 the secondary command port, 0x0A1 the secondary data port, 0x4D0 the primary trigger register and 0x4D1 the secondary trigger register. A write to any other address changes nothing, and a read of any other address returns 0x00.
- R2: An access with io_size other than 0 (0 means one byte) does not act. Its write changes nothing, and its read returns 0x00 with no side effect.
- R3: irq_lines[7:0] are primary lines 0–7 and irq_lines[15:8] are secondary lines 0–7. A line whose trigger bit is 0 requests on a rising edge only, so holding it high after service raises no new request. A line whose trigger bit is 1 requests for as long as it is high, and its request drops when the line goes low.
- R4: Only bits 0xF8 of the primary trigger register and bits 0xDE of the secondary trigger register can be written. Reading the register returns the stored value.
- R5: While the secondary has a serviceable request that is not being consumed in the same cycle, request bit 2 of the primary is set on the next clock.
- R6: When an acknowledge finds a primary winner L other than 2, ack_vec is {primary base[7:3], L}. The acknowledge sets the in-service bit for L and clears L's request if L is edge-triggered.
- R7: When the primary winner is line 2, the secondary winner S is acknowledged too, and ack_vec is {secondary base[7:3], S}. If the secondary has no winner, ack_vec is {secondary base[7:3], 7}.
- R8: An acknowledge that finds no primary winner returns {primary base[7:3], 7} and changes no state.
- R9: A command write with bit 4 = 0, bit 3 = 1 and bit 2 = 1 arms a poll. The next byte read of that core returns 0x80 | winner and clears that line's request and in-service bits, or returns 0x07 if there is no winner. A secondary poll that finds a winner also clears request bit 2 and in-service bit 2 of the primary.
- R10: irq_o is a register that follows, one clock later, whether the primary has a winner. wake_o is high for exactly the cycle in which irq_o goes from 0 to 1.
- R11: Of the requests that are not masked, the lowest line number wins. A winner exists only if its line is numbered below every in-service line of its core. Mask bit n = 1 blocks line n.
- R12: Command 0x20 clears the lowest-numbered in-service bit. Command 0x60 | n clears in-service bit n.
- R13: A command write with bit 4 = 1 clears the mask, the in-service bits and the edge-triggered requests, and selects request readback. The next data-port write sets vector base bits 7:3. At reset the bases are 0x08 (primary) and 0x70 (secondary).
- R14: A command write of 0x0A makes a command-port read return the request bits, and 0x0B makes it return the in-service bits. A data-port read returns the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | Interrupt lines, primary in 7:0 and secondary in 15:8 |
| io_addr | input | 16 | I/O address |
| io_size | input | 2 | Access size code; 0 means one byte |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, registered |
| io_rvalid | output | 1 | High in the cycle after a read strobe |
| ack_req | input | 1 | CPU acknowledge strobe |
| ack_vec | output | 8 | Vector returned for the last acknowledge |
| ack_valid | output | 1 | High in the cycle after ack_req |
| irq_o | output | 1 | Interrupt request to the CPU |
| wake_o | output | 1 | One-cycle strobe on a rising irq_o |

## Verification
On every cycle, the assertions check the cascade link from a serviceable secondary request to primary bit 2. They also check the vector layout at each acknowledge level, including the spurious vector when there is no primary winner, and that a wide read returns zero. Further per-cycle checks cover in-service marking on acknowledge, the clearing effect of re-initialisation, and the coincidence of the wake strobe with a rising output. Some behaviour only the bench's scenarios can show: the full sweep of all sixteen lines, priority between nested requests, mask and EOI ordering, level versus edge retriggering, poll side effects across both cores, and re-basing of the vector through the initialisation sequence.

// File: rtl/cpic_pkg.sv
package cpic_pkg;
  localparam int LINES = 8;
  localparam int IDXW  = $clog2(LINES);
  localparam logic [IDXW-1:0] CAS_LINE  = IDXW'(2);
  localparam logic [IDXW-1:0] SPUR_LINE = IDXW'(LINES - 1);

  typedef struct packed {
    logic            valid;
    logic [IDXW-1:0] idx;
  } pick_t;

  typedef struct packed {
    logic pri_cmd;
    logic pri_dat;
    logic sec_cmd;
    logic sec_dat;
    logic pri_trig;
    logic sec_trig;
  } io_sel_t;

  typedef enum logic {ST_RUN, ST_BASE} cfg_st_t;

  // lowest set bit wins
  function automatic pick_t pick_low(input logic [LINES-1:0] v);
    pick_t r;
    r = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (v[i]) begin
        r.valid = 1'b1;
        r.idx   = IDXW'(i);
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] vec_of(input logic [7-IDXW:0] base, input logic [IDXW-1:0] idx);
    return {base, idx};
  endfunction

  function automatic logic [7:0] poll_byte(input pick_t w);
    return w.valid ? {1'b1, {(7-IDXW){1'b0}}, w.idx} : 8'h07;
  endfunction

  function automatic logic [7:0] ack_vector(input pick_t pw, input pick_t sw,
                                            input logic [7-IDXW:0] pb, input logic [7-IDXW:0] sb);
    if (!pw.valid)            return vec_of(pb, SPUR_LINE);
    else if (pw.idx != CAS_LINE) return vec_of(pb, pw.idx);
    else if (sw.valid)        return vec_of(sb, sw.idx);
    else                      return vec_of(sb, SPUR_LINE);
  endfunction
endpackage

// File: rtl/pic_addr_dec.sv
module pic_addr_dec
  import cpic_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PRI_PORT  = 'h020,
  parameter logic [ADDR_W-1:0] SEC_PORT  = 'h0A0,
  parameter logic [ADDR_W-1:0] TRIG_PORT = 'h4D0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output io_sel_t           sel_o
);
  logic byte_ok;
  logic [ADDR_W-2:0] pair;

  assign byte_ok = (size_i == 2'd0);
  assign pair    = addr_i[ADDR_W-1:1];

  always_comb begin
    sel_o = '0;
    if (byte_ok) begin
      sel_o.pri_cmd  = (pair == PRI_PORT[ADDR_W-1:1])  && !addr_i[0];
      sel_o.pri_dat  = (pair == PRI_PORT[ADDR_W-1:1])  &&  addr_i[0];
      sel_o.sec_cmd  = (pair == SEC_PORT[ADDR_W-1:1])  && !addr_i[0];
      sel_o.sec_dat  = (pair == SEC_PORT[ADDR_W-1:1])  &&  addr_i[0];
      sel_o.pri_trig = (pair == TRIG_PORT[ADDR_W-1:1]) && !addr_i[0];
      sel_o.sec_trig = (pair == TRIG_PORT[ADDR_W-1:1]) &&  addr_i[0];
    end
  end

  a_r1_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel_o));
  a_r2_wide_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (size_i != 2'd0) |-> (sel_o == '0));
endmodule

// File: rtl/pic_core.sv
module pic_core
  import cpic_pkg::*;
#(
  parameter logic [LINES-1:0] TRIG_WMASK = '1,
  parameter logic [7-IDXW:0]  BASE_RST   = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines_i,
  input  logic [LINES-1:0] cas_set_i,
  input  logic             wr_cmd_i,
  input  logic             wr_data_i,
  input  logic             wr_trig_i,
  input  logic [7:0]       wdata_i,
  input  logic             rd_any_i,
  input  logic             ack_i,
  input  logic [LINES-1:0] clr_i,
  output pick_t            win_o,
  output logic [LINES-1:0] irr_o,
  output logic [LINES-1:0] isr_o,
  output logic [LINES-1:0] imr_o,
  output logic [LINES-1:0] trig_o,
  output logic [7-IDXW:0]  base_o,
  output logic             rd_isr_o,
  output logic             poll_o
);
  logic [LINES-1:0] irr_q, isr_q, imr_q, trig_q, last_q, irr_n, isr_n, edge_set;
  logic [7-IDXW:0]  base_q;
  logic             rd_isr_q, poll_q;
  cfg_st_t          st_q;
  pick_t            best, cur;
  logic             init_cmd, ctl_cmd, eoi_low, eoi_pick;

  assign best = pick_low(irr_q & ~imr_q);
  assign cur  = pick_low(isr_q);
  always_comb begin
    win_o.idx   = best.idx;
    win_o.valid = best.valid && (!cur.valid || (best.idx < cur.idx));
  end

  assign init_cmd = wr_cmd_i && wdata_i[4];
  assign ctl_cmd  = wr_cmd_i && !wdata_i[4] && wdata_i[3];
  assign eoi_low  = wr_cmd_i && !wdata_i[4] && !wdata_i[3] && (wdata_i[7:5] == 3'b001);
  assign eoi_pick = wr_cmd_i && !wdata_i[4] && !wdata_i[3] && (wdata_i[7:5] == 3'b011);
  assign edge_set = lines_i & ~last_q & ~trig_q;

  always_comb begin
    isr_n = isr_q;
    if (ack_i) isr_n[win_o.idx] = 1'b1;
    if (eoi_low && cur.valid) isr_n[cur.idx] = 1'b0;
    if (eoi_pick) isr_n[wdata_i[IDXW-1:0]] = 1'b0;
    isr_n = isr_n & ~clr_i;
    if (init_cmd) isr_n = '0;

    irr_n = irr_q;
    if (ack_i && !trig_q[win_o.idx]) irr_n[win_o.idx] = 1'b0;
    irr_n = irr_n & ~clr_i;
    if (init_cmd) irr_n = irr_n & trig_q;
    irr_n = (irr_n & ~trig_q) | (lines_i & trig_q) | edge_set | cas_set_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q <= '0; isr_q <= '0; imr_q <= '0; trig_q <= '0; last_q <= '0;
      base_q <= BASE_RST; rd_isr_q <= 1'b0; poll_q <= 1'b0; st_q <= ST_RUN;
    end else begin
      irr_q  <= irr_n;
      isr_q  <= isr_n;
      last_q <= init_cmd ? '0 : lines_i;
      if (wr_trig_i) trig_q <= wdata_i[LINES-1:0] & TRIG_WMASK;
      if (init_cmd) begin
        imr_q <= '0; rd_isr_q <= 1'b0; poll_q <= 1'b0; st_q <= ST_BASE;
      end else if (wr_data_i) begin
        if (st_q == ST_BASE) begin
          base_q <= wdata_i[7:IDXW];
          st_q   <= ST_RUN;
        end else begin
          imr_q <= wdata_i[LINES-1:0];
        end
      end
      if (ctl_cmd && wdata_i[1]) rd_isr_q <= wdata_i[0];
      if (ctl_cmd && wdata_i[2]) poll_q <= 1'b1;
      else if (rd_any_i) poll_q <= 1'b0;
    end
  end

  assign irr_o = irr_q;  assign isr_o = isr_q;  assign imr_o = imr_q;
  assign trig_o = trig_q; assign base_o = base_q;
  assign rd_isr_o = rd_isr_q; assign poll_o = poll_q;

  a_r6_ack_marks_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !wr_cmd_i && (clr_i == '0)) |=> isr_q[$past(win_o.idx)]);
  a_r13_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    init_cmd |=> (imr_q == '0) && (isr_q == '0));
  a_r4_trig_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q & ~TRIG_WMASK) == '0);
endmodule

// File: rtl/pic_ack_seq.sv
module pic_ack_seq
  import cpic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack_req_i,
  input  pick_t           pri_win_i,
  input  pick_t           sec_win_i,
  input  logic [7-IDXW:0] pri_base_i,
  input  logic [7-IDXW:0] sec_base_i,
  output logic            pri_ack_o,
  output logic            sec_ack_o,
  output logic [7:0]      ack_vec_o,
  output logic            ack_valid_o
);
  logic to_sec;

  assign pri_ack_o = ack_req_i && pri_win_i.valid;
  assign to_sec    = pri_ack_o && (pri_win_i.idx == CAS_LINE);
  assign sec_ack_o = to_sec && sec_win_i.valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_vec_o   <= '0;
      ack_valid_o <= 1'b0;
    end else begin
      ack_valid_o <= ack_req_i;
      if (ack_req_i) ack_vec_o <= ack_vector(pri_win_i, sec_win_i, pri_base_i, sec_base_i);
    end
  end

  a_r8_spurious_primary: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req_i && !pri_win_i.valid) |=> ack_valid_o && (ack_vec_o[IDXW-1:0] == SPUR_LINE)
      && (ack_vec_o[7:IDXW] == $past(pri_base_i)));
  a_r7_falls_to_secondary: assert property (@(posedge clk) disable iff (!rst_n)
    to_sec |=> (ack_vec_o[7:IDXW] == $past(sec_base_i)));
  a_r6_primary_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_ack_o && !to_sec) |=> (ack_vec_o[IDXW-1:0] == $past(pri_win_i.idx)));
endmodule

// File: rtl/cascade_pic.sv
module cascade_pic
  import cpic_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PRI_PORT  = 'h020,
  parameter logic [ADDR_W-1:0] SEC_PORT  = 'h0A0,
  parameter logic [ADDR_W-1:0] TRIG_PORT = 'h4D0,
  parameter logic [LINES-1:0]  PRI_TRIG_WMASK = 8'hF8,
  parameter logic [LINES-1:0]  SEC_TRIG_WMASK = 8'hDE,
  parameter logic [7-IDXW:0]   PRI_BASE_RST = 5'b00001,
  parameter logic [7-IDXW:0]   SEC_BASE_RST = 5'b01110
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*LINES-1:0] irq_lines,
  input  logic [ADDR_W-1:0]  io_addr,
  input  logic [1:0]         io_size,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic [7:0]         io_wdata,
  output logic [7:0]         io_rdata,
  output logic               io_rvalid,
  input  logic               ack_req,
  output logic [7:0]         ack_vec,
  output logic               ack_valid,
  output logic               irq_o,
  output logic               wake_o
);
  io_sel_t sel;
  pick_t   pri_win, sec_win;
  logic [LINES-1:0] pri_irr, pri_isr, pri_imr, pri_trig, sec_irr, sec_isr, sec_imr, sec_trig;
  logic [7-IDXW:0]  pri_base, sec_base;
  logic pri_rd_isr, sec_rd_isr, pri_poll, sec_poll;
  logic pri_ack, sec_ack;
  logic pri_rd_hit, sec_rd_hit, pri_poll_hit, sec_poll_hit, sec_consumed, cas_pulse;
  logic [LINES-1:0] pri_clr, sec_clr, cas_set;
  logic [7:0] rd_next;
  logic irq_q, wake_q;

  pic_addr_dec #(.ADDR_W(ADDR_W), .PRI_PORT(PRI_PORT), .SEC_PORT(SEC_PORT), .TRIG_PORT(TRIG_PORT))
    u_dec (.clk(clk), .rst_n(rst_n), .addr_i(io_addr), .size_i(io_size), .sel_o(sel));

  assign pri_rd_hit   = io_rd && (sel.pri_cmd || sel.pri_dat);
  assign sec_rd_hit   = io_rd && (sel.sec_cmd || sel.sec_dat);
  assign pri_poll_hit = pri_rd_hit && pri_poll && pri_win.valid;
  assign sec_poll_hit = sec_rd_hit && sec_poll && sec_win.valid;

  // the secondary winner leaves this cycle: do not re-announce it on line 2
  assign sec_consumed = sec_ack || sec_poll_hit;
  assign cas_pulse    = sec_win.valid && !sec_consumed;
  always_comb begin
    cas_set = '0;
    cas_set[CAS_LINE] = cas_pulse;
    pri_clr = '0;
    if (pri_poll_hit) pri_clr[pri_win.idx] = 1'b1;
    if (sec_poll_hit) pri_clr[CAS_LINE] = 1'b1;
    sec_clr = '0;
    if (sec_poll_hit) sec_clr[sec_win.idx] = 1'b1;
  end

  pic_core #(.TRIG_WMASK(PRI_TRIG_WMASK), .BASE_RST(PRI_BASE_RST)) u_pri (
    .clk(clk), .rst_n(rst_n), .lines_i(irq_lines[LINES-1:0]), .cas_set_i(cas_set),
    .wr_cmd_i(io_wr && sel.pri_cmd), .wr_data_i(io_wr && sel.pri_dat),
    .wr_trig_i(io_wr && sel.pri_trig), .wdata_i(io_wdata), .rd_any_i(pri_rd_hit),
    .ack_i(pri_ack), .clr_i(pri_clr), .win_o(pri_win), .irr_o(pri_irr), .isr_o(pri_isr),
    .imr_o(pri_imr), .trig_o(pri_trig), .base_o(pri_base), .rd_isr_o(pri_rd_isr), .poll_o(pri_poll));

  pic_core #(.TRIG_WMASK(SEC_TRIG_WMASK), .BASE_RST(SEC_BASE_RST)) u_sec (
    .clk(clk), .rst_n(rst_n), .lines_i(irq_lines[2*LINES-1:LINES]), .cas_set_i('0),
    .wr_cmd_i(io_wr && sel.sec_cmd), .wr_data_i(io_wr && sel.sec_dat),
    .wr_trig_i(io_wr && sel.sec_trig), .wdata_i(io_wdata), .rd_any_i(sec_rd_hit),
    .ack_i(sec_ack), .clr_i(sec_clr), .win_o(sec_win), .irr_o(sec_irr), .isr_o(sec_isr),
    .imr_o(sec_imr), .trig_o(sec_trig), .base_o(sec_base), .rd_isr_o(sec_rd_isr), .poll_o(sec_poll));

  pic_ack_seq u_ack (
    .clk(clk), .rst_n(rst_n), .ack_req_i(ack_req), .pri_win_i(pri_win), .sec_win_i(sec_win),
    .pri_base_i(pri_base), .sec_base_i(sec_base), .pri_ack_o(pri_ack), .sec_ack_o(sec_ack),
    .ack_vec_o(ack_vec), .ack_valid_o(ack_valid));

  always_comb begin
    rd_next = '0;
    if (sel.pri_cmd)       rd_next = pri_poll ? poll_byte(pri_win) : (pri_rd_isr ? pri_isr : pri_irr);
    else if (sel.pri_dat)  rd_next = pri_poll ? poll_byte(pri_win) : pri_imr;
    else if (sel.sec_cmd)  rd_next = sec_poll ? poll_byte(sec_win) : (sec_rd_isr ? sec_isr : sec_irr);
    else if (sel.sec_dat)  rd_next = sec_poll ? poll_byte(sec_win) : sec_imr;
    else if (sel.pri_trig) rd_next = pri_trig;
    else if (sel.sec_trig) rd_next = sec_trig;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_rdata <= '0; io_rvalid <= 1'b0; irq_q <= 1'b0; wake_q <= 1'b0;
    end else begin
      io_rvalid <= io_rd;
      if (io_rd) io_rdata <= rd_next;
      irq_q  <= pri_win.valid;
      wake_q <= pri_win.valid && !irq_q;
    end
  end
  assign irq_o  = irq_q;
  assign wake_o = wake_q;

  a_r10_wake_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (irq_o && !$past(irq_o)));
  a_r10_rise_has_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> wake_o);
  a_r5_cascade_link: assert property (@(posedge clk) disable iff (!rst_n)
    cas_pulse |=> pri_irr[CAS_LINE]);
  a_r2_wide_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_size != 2'd0) |=> (io_rdata == 8'h00));
endmodule

// File: tb/sim_cascade_pic.sv
module sim_cascade_pic;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] irq_lines = '0, io_addr = '0;
  logic [1:0]  io_size = '0;
  logic io_wr = 1'b0, io_rd = 1'b0, ack_req = 1'b0;
  logic [7:0] io_wdata = '0, io_rdata, ack_vec;
  logic io_rvalid, ack_valid, irq_o, wake_o;
  int total = 0, bad = 0, wakes = 0;
  bit done = 1'b0;
  localparam logic [7:0] PB = 8'h08, SB = 8'h70;

  always #4 clk = ~clk;

  cascade_pic u0 (.clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .io_addr(io_addr),
    .io_size(io_size), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_rvalid(io_rvalid), .ack_req(ack_req), .ack_vec(ack_vec), .ack_valid(ack_valid),
    .irq_o(irq_o), .wake_o(wake_o));

  always @(posedge clk) if (rst_n && wake_o) wakes++;

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic settle(input int n = 4);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [1:0] sz = 2'd0);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_size = sz; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_size = 2'd0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d, input logic [1:0] sz = 2'd0);
    @(negedge clk);
    io_addr = a; io_size = sz; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0; io_size = 2'd0;
    d = io_rdata;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk);
    ack_req = 1'b1;
    @(negedge clk);
    ack_req = 1'b0;
    v = ack_vec;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int w0;
    settle(3);
    rst_n = 1'b1;
    settle(2);
    chk("reset irq_o R10", int'(irq_o), 0);
    rd(16'h021, v); chk("reset mask R14", v, 0);

    // R3 R6 R7 R10 R12: sweep all sixteen lines
    for (int l = 0; l < 16; l++) begin
      w0 = wakes;
      irq_lines[l] = 1'b1;
      settle();
      chk($sformatf("line %0d irq R10", l), int'(irq_o), 1);
      chk($sformatf("line %0d wake R10", l), wakes - w0, 1);
      ack(v);
      if (l == 2)      chk("pin2 spurious secondary R7", v, SB + 7);
      else if (l < 8)  chk($sformatf("line %0d vector R6", l), v, PB + l);
      else             chk($sformatf("line %0d vector R7 R3", l), v, SB + (l - 8));
      irq_lines[l] = 1'b0;
      settle();
      if (l >= 8) wr(16'h0A0, 8'h20);
      wr(16'h020, 8'h20);
      settle();
      chk($sformatf("line %0d quiet after EOI R12", l), int'(irq_o), 0);
    end

    // R11 R8 R12 R14: nesting
    irq_lines[5] = 1'b1; irq_lines[3] = 1'b1; settle();
    ack(v); chk("lower line wins R11", v, PB + 3);
    irq_lines[1] = 1'b1; settle();
    ack(v); chk("nested higher R11", v, PB + 1);
    settle();
    chk("blocked by service R11", int'(irq_o), 0);
    ack(v); chk("spurious primary R8", v, PB + 7);
    wr(16'h020, 8'h0B); rd(16'h020, v); chk("in-service read R14", v, 8'h0A);
    wr(16'h020, 8'h20); rd(16'h020, v); chk("nonspecific EOI R12", v, 8'h08);
    wr(16'h020, 8'h63); rd(16'h020, v); chk("specific EOI R12", v, 8'h00);
    wr(16'h020, 8'h0A); rd(16'h020, v); chk("request read R14", v, 8'h20);
    ack(v); chk("pending after EOI R11", v, PB + 5);
    wr(16'h020, 8'h20);
    irq_lines[5] = 1'b0; irq_lines[3] = 1'b0; irq_lines[1] = 1'b0;

    // R3 edge held high does not retrigger
    irq_lines[6] = 1'b1; settle(); ack(v); wr(16'h020, 8'h20); settle();
    chk("edge held no retrigger R3", int'(irq_o), 0);
    irq_lines[6] = 1'b0;

    // R11 R14 mask
    wr(16'h021, 8'h10); irq_lines[4] = 1'b1; settle();
    chk("masked line R11", int'(irq_o), 0);
    rd(16'h021, v); chk("mask read R14", v, 8'h10);
    wr(16'h021, 8'h00); settle();
    chk("unmasked line R11", int'(irq_o), 1);
    ack(v); chk("unmasked vector R6", v, PB + 4);
    irq_lines[4] = 1'b0; wr(16'h020, 8'h20);

    // R1 R2 decode and size
    wr(16'h022, 8'hFF); rd(16'h021, v); chk("stray write R1", v, 0);
    rd(16'h022, v); chk("stray read R1", v, 0);
    rd(16'h4D2, v); chk("stray read high R1", v, 0);
    wr(16'h021, 8'h55);
    rd(16'h021, v, 2'd2); chk("wide read zero R2", v, 0);
    wr(16'h021, 8'hFF, 2'd1); rd(16'h021, v); chk("wide write ignored R2", v, 8'h55);
    wr(16'h0A1, 8'h3C); rd(16'h0A1, v); chk("secondary data port R1", v, 8'h3C);
    rd(16'h021, v); chk("primary untouched R1", v, 8'h55);
    wr(16'h021, 8'h00); wr(16'h0A1, 8'h00);

    // R4 trigger registers, R3 level mode
    wr(16'h4D0, 8'hFF); rd(16'h4D0, v); chk("primary trig mask R4", v, 8'hF8);
    wr(16'h4D1, 8'hFF); rd(16'h4D1, v); chk("secondary trig mask R4", v, 8'hDE);
    wr(16'h4D1, 8'h00);
    wr(16'h4D0, 8'h10);
    irq_lines[4] = 1'b1; settle();
    ack(v); chk("level vector R6", v, PB + 4);
    rd(16'h020, v); chk("level stays requested R3", v, 8'h10);
    wr(16'h020, 8'h20); settle();
    chk("level re-requests R3", int'(irq_o), 1);
    irq_lines[4] = 1'b0; settle();
    chk("level drops R3", int'(irq_o), 0);
    wr(16'h4D0, 8'h00);

    // R5 cascade, R9 poll
    irq_lines[9] = 1'b1; settle();
    rd(16'h020, v); chk("cascade sets bit2 R5", v, 8'h04);
    wr(16'h0A0, 8'h0C); rd(16'h0A0, v); chk("secondary poll R9", v, 8'h81);
    settle(2);
    rd(16'h020, v); chk("poll clears primary bit2 R9", v, 8'h00);
    settle();
    chk("quiet after poll R9", int'(irq_o), 0);
    irq_lines[9] = 1'b0;
    irq_lines[3] = 1'b1; settle();
    wr(16'h020, 8'h0C); rd(16'h020, v); chk("primary poll R9", v, 8'h83);
    settle(); chk("primary poll consumed R9", int'(irq_o), 0);
    irq_lines[3] = 1'b0;
    wr(16'h020, 8'h0C); rd(16'h020, v); chk("empty poll R9", v, 8'h07);

    // R13 init re-bases primary
    wr(16'h021, 8'h33);
    wr(16'h020, 8'h11); wr(16'h021, 8'h40);
    rd(16'h021, v); chk("init clears mask R13", v, 0);
    irq_lines[1] = 1'b1; settle();
    ack(v); chk("new base R13", v, 8'h41);
    irq_lines[1] = 1'b0; wr(16'h020, 8'h20);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule